// File: doc/BRIEF.md
# Stuff-Code Frame Synchronizer

This block recovers minor-frame alignment for a time-division demultiplexer. It takes one overhead bit per received word, which is the least significant bit of that word. Every minor frame carries a 23-bit stuff command in its overhead bits, in words 1 through 23. The command is one of three fixed codes. A code tells the far-end stuffing logic to do nothing, to add a positive stuff, or to add a negative stuff. The three codes double as the frame alignment pattern.

Acquisition runs in two steps. While hunting, the block compares a sliding window of the latest 11 overhead bits against the leading 11 bits of all three codes, once per bit. A hit emits a one-cycle provisional strobe and presets the word counter to word 11. The remaining 12 bits of that same code must then arrive in words 12 to 23 of the same frame. If they do, frame sync is declared. If they do not, hunting resumes with the next bit.

Once locked, the hunt is disabled. Every frame is compared against all three codes. The frame-sync flag drops as soon as no code is still consistent with the bits received. At word 23 of every fully matching frame, the received code is decoded into the stuff enables. The frame-sync flag is the gate that downstream data output and error-rate checking use.

Top module: `stuff_frame_sync`

## Requirements
- R1: Each cycle with `word_en` high is reflected on the next cycle as `ovh_valid` high and `ovh_bit` equal to `ovh_in`. `ovh_valid` is low after a cycle without `word_en`.
- R2: While hunting, the 11-bit window is checked against the leading 11 bits of each code (code bits 22 down to 12) on every overhead bit. The window is cleared to zeros by reset, and its oldest bit is compared with code bit 22. The bit of a code carried in word w (1 to 23) is code bit 23−w. A hit gives a one-cycle `prov_sync` pulse together with `word_idx` = 11.
- R3: `word_idx` holds the index of the last received word. It steps by one per word, wraps from FRAME_WORDS−1 to 0, and holds when `word_enable` is low. `frame_end` pulses in the cycle in which `word_idx` becomes FRAME_WORDS−1.
- R4: After a provisional strobe, if words 12 to 23 all match the same code, `frame_sync` rises in the cycle after word 23.
- R5: If any of words 12 to 23 disagrees with the acquired code, `frame_sync` stays low and hunting restarts with the following overhead bit.
- R6: No `prov_sync` pulse occurs while `frame_sync` is high.
- R7: In lock, `frame_sync` falls in the cycle after the first word in the range 1 to 23 where no code still agrees with every bit received since word 1 of that frame.
- R8: Code index 0 (CODE_NONE) gives neither enable, CODE_POS gives `stuff_pos`, and CODE_NEG gives `stuff_neg`. The enables are loaded at word 23 of each fully matched frame and are held otherwise.
- R9: `stuff_pos` and `stuff_neg` are low whenever `frame_sync` is low.
- R10: During reset, every output is low except `word_idx`, which is FRAME_WORDS−1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| word_en | input | 1 | One-cycle strobe per received word |
| ovh_in | input | 1 | Overhead bit (bit 0) of the received word |
| ovh_valid | output | 1 | Registered copy of word_en |
| ovh_bit | output | 1 | Registered overhead bit |
| word_idx | output | $clog2(FRAME_WORDS) | Index of the last received word in the minor frame |
| frame_end | output | 1 | Pulse when the last word of a frame is received |
| prov_sync | output | 1 | Provisional sync strobe on an 11-bit prefix hit |
| frame_sync | output | 1 | Frame synchronization established |
| stuff_pos | output | 1 | Positive stuff command received |
| stuff_neg | output | 1 | Negative stuff command received |

## Verification
Some rules are checked by the bound assertions on every cycle:
- the word counter steps, holds and presets as specified;
- lock is only entered at word 23 and only dropped in a code word;
- no provisional strobe appears while locked;
- the stuff enables are exclusive, forced low without sync, and frozen between word-23 updates.

Other behaviour depends on the actual bit patterns, so only the bench's scenarios can show it:
- that the right code is recognised at the right bit position;
- that a failed confirmation releases the hunt on the very next bit;
- that loss of lock happens at the corrupted word;
- that false prefixes in random traffic are handled.

// File: rtl/stuff_frame_sync_pkg.sv
package stuff_frame_sync_pkg;

  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_VERIFY = 2'd1,
    ST_LOCKED = 2'd2
  } sync_state_e;

  localparam int unsigned N_CODES  = 3;
  localparam int unsigned IDX_NONE = 0;
  localparam int unsigned IDX_POS  = 1;
  localparam int unsigned IDX_NEG  = 2;

endpackage

// File: rtl/sfs_prefix_window.sv
// Sliding window of the most recent overhead bits with one prefix comparator per code.
module sfs_prefix_window #(
  parameter int unsigned CODE_LEN   = 23,
  parameter int unsigned PREFIX_LEN = 11,
  parameter int unsigned N_CODES    = 3,
  parameter logic [N_CODES-1:0][CODE_LEN-1:0] CODES = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               bit_in,
  output logic [N_CODES-1:0] hit
);

  logic [PREFIX_LEN-2:0] win_q;
  logic [PREFIX_LEN-1:0] win_n;

  // Oldest bit at the MSB, so it lines up with the first code bit sent.
  always_comb begin
    win_n = {win_q, bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else if (shift_en) begin
      win_q <= win_n[PREFIX_LEN-2:0];
    end
  end

  for (genvar k = 0; k < N_CODES; k++) begin : g_cmp
    assign hit[k] = shift_en && (win_n == CODES[k][CODE_LEN-1 -: PREFIX_LEN]);
  end

endmodule

// File: rtl/sfs_word_counter.sv
// Word position within the minor frame, with a preset for alignment.
module sfs_word_counter #(
  parameter int unsigned FRAME_WORDS = 32,
  parameter int unsigned PRESET      = 11
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           adv,
  input  logic                           preset,
  output logic [$clog2(FRAME_WORDS)-1:0] idx_q,
  output logic [$clog2(FRAME_WORDS)-1:0] cur,
  output logic [$clog2(FRAME_WORDS)-1:0] idx_n
);

  localparam int unsigned CNT_W = $clog2(FRAME_WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_WORDS - 1);

  // cur is the index the arriving word takes without a preset.
  always_comb begin
    cur   = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    idx_n = preset ? CNT_W'(PRESET) : cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= LAST;
    end else if (adv) begin
      idx_q <= idx_n;
    end
  end

endmodule

// File: rtl/sfs_code_tracker.sv
// Per-code flags of "every code bit so far in this frame agreed".
module sfs_code_tracker #(
  parameter int unsigned CODE_LEN = 23,
  parameter int unsigned N_CODES  = 3,
  parameter int unsigned CNT_W    = 5,
  parameter logic [N_CODES-1:0][CODE_LEN-1:0] CODES = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               bit_in,
  input  logic [CNT_W-1:0]   cur,
  input  logic               load,
  input  logic [N_CODES-1:0] load_vec,
  output logic [N_CODES-1:0] live_n,
  output logic               in_code,
  output logic               last_code
);

  logic [N_CODES-1:0] live_q;
  logic [N_CODES-1:0] agree;

  always_comb begin
    in_code   = (cur != '0) && (cur <= CNT_W'(CODE_LEN));
    last_code = (cur == CNT_W'(CODE_LEN));
  end

  for (genvar k = 0; k < N_CODES; k++) begin : g_code
    logic exp_bit;
    always_comb begin
      exp_bit = 1'b0;
      for (int w = 1; w <= CODE_LEN; w++) begin
        if (cur == CNT_W'(w)) begin
          exp_bit = CODES[k][CODE_LEN-w];
        end
      end
    end
    assign agree[k] = (exp_bit == bit_in);
  end

  // Word 1 starts a fresh comparison; later code words narrow the set.
  always_comb begin
    if (load) begin
      live_n = load_vec;
    end else if (in_code) begin
      live_n = (cur == CNT_W'(1)) ? agree : (live_q & agree);
    end else begin
      live_n = live_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
    end else if (adv) begin
      live_q <= live_n;
    end
  end

endmodule

// File: rtl/stuff_frame_sync.sv
module stuff_frame_sync
  import stuff_frame_sync_pkg::*;
#(
  parameter int unsigned FRAME_WORDS = 32,
  parameter int unsigned CODE_LEN    = 23,
  parameter int unsigned PREFIX_LEN  = 11,
  parameter logic [CODE_LEN-1:0] CODE_NONE = 23'h2B4D1E,
  parameter logic [CODE_LEN-1:0] CODE_POS  = 23'h65A0F3,
  parameter logic [CODE_LEN-1:0] CODE_NEG  = 23'h1C7E2D
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           word_en,
  input  logic                           ovh_in,
  output logic                           ovh_valid,
  output logic                           ovh_bit,
  output logic [$clog2(FRAME_WORDS)-1:0] word_idx,
  output logic                           frame_end,
  output logic                           prov_sync,
  output logic                           frame_sync,
  output logic                           stuff_pos,
  output logic                           stuff_neg
);

  localparam int unsigned CNT_W = $clog2(FRAME_WORDS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_WORDS - 1);
  localparam logic [N_CODES-1:0][CODE_LEN-1:0] CODES = {CODE_NEG, CODE_POS, CODE_NONE};

  sync_state_e        state_q, state_n;
  logic [N_CODES-1:0] hit;
  logic [N_CODES-1:0] live_n;
  logic               in_code, last_code, load;
  logic [CNT_W-1:0]   cur, idx_n;
  logic               pos_q, pos_n, neg_q, neg_n;
  logic               valid_q, bit_q, prov_q, end_q;

  sfs_prefix_window #(
    .CODE_LEN(CODE_LEN), .PREFIX_LEN(PREFIX_LEN), .N_CODES(N_CODES), .CODES(CODES)
  ) u_window (
    .clk(clk), .rst_n(rst_n), .shift_en(word_en), .bit_in(ovh_in), .hit(hit)
  );

  // A prefix hit is only acted upon while hunting.
  assign load = word_en && (state_q == ST_HUNT) && (|hit);

  sfs_word_counter #(
    .FRAME_WORDS(FRAME_WORDS), .PRESET(PREFIX_LEN)
  ) u_counter (
    .clk(clk), .rst_n(rst_n), .adv(word_en), .preset(load),
    .idx_q(word_idx), .cur(cur), .idx_n(idx_n)
  );

  sfs_code_tracker #(
    .CODE_LEN(CODE_LEN), .N_CODES(N_CODES), .CNT_W(CNT_W), .CODES(CODES)
  ) u_tracker (
    .clk(clk), .rst_n(rst_n), .adv(word_en), .bit_in(ovh_in), .cur(cur),
    .load(load), .load_vec(hit), .live_n(live_n), .in_code(in_code),
    .last_code(last_code)
  );

  always_comb begin
    state_n = state_q;
    pos_n   = pos_q;
    neg_n   = neg_q;
    if (word_en) begin
      unique case (state_q)
        ST_HUNT: begin
          if (load) begin
            state_n = ST_VERIFY;
          end
        end
        ST_VERIFY, ST_LOCKED: begin
          if (in_code) begin
            if (live_n == '0) begin
              state_n = ST_HUNT;
            end else if (last_code) begin
              state_n = ST_LOCKED;
              pos_n   = live_n[IDX_POS];
              neg_n   = live_n[IDX_NEG];
            end
          end
        end
        default: state_n = ST_HUNT;
      endcase
    end
    if (state_n != ST_LOCKED) begin
      pos_n = 1'b0;
      neg_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HUNT;
      pos_q   <= 1'b0;
      neg_q   <= 1'b0;
    end else if (word_en) begin
      state_q <= state_n;
      pos_q   <= pos_n;
      neg_q   <= neg_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      prov_q  <= 1'b0;
      end_q   <= 1'b0;
    end else begin
      valid_q <= word_en;
      prov_q  <= load;
      end_q   <= word_en && (idx_n == LAST);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
    end else if (word_en) begin
      bit_q <= ovh_in;
    end
  end

  assign ovh_valid  = valid_q;
  assign ovh_bit    = bit_q;
  assign frame_end  = end_q;
  assign prov_sync  = prov_q;
  assign frame_sync = (state_q == ST_LOCKED);
  assign stuff_pos  = pos_q;
  assign stuff_neg  = neg_q;

endmodule

// File: rtl/stuff_frame_sync_chk.sv
module stuff_frame_sync_chk #(
  parameter int unsigned FRAME_WORDS = 32,
  parameter int unsigned CODE_LEN    = 23,
  parameter int unsigned PREFIX_LEN  = 11
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           word_en,
  input logic                           ovh_in,
  input logic                           ovh_valid,
  input logic                           ovh_bit,
  input logic [$clog2(FRAME_WORDS)-1:0] word_idx,
  input logic                           frame_end,
  input logic                           prov_sync,
  input logic                           frame_sync,
  input logic                           stuff_pos,
  input logic                           stuff_neg
);

  localparam int unsigned IDX_W = $clog2(FRAME_WORDS);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_WORDS - 1);

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ovh_valid == $past(word_en));

  a_r1_bit_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ovh_valid |-> ovh_bit == $past(ovh_in));

  a_r3_idx_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (ovh_valid && !prov_sync) |->
      (($past(word_idx) == LAST) ? (word_idx == '0) : (word_idx == $past(word_idx) + 1'b1)));

  a_r3_idx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !ovh_valid |-> $stable(word_idx));

  a_r3_end_at_last: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> (ovh_valid && word_idx == LAST));

  a_r2_prov_preset: assert property (@(posedge clk) disable iff (!rst_n)
    prov_sync |-> (ovh_valid && word_idx == IDX_W'(PREFIX_LEN) && !frame_sync));

  a_r6_no_prov_locked: assert property (@(posedge clk) disable iff (!rst_n)
    prov_sync |-> !$past(frame_sync));

  a_r4_lock_at_code_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_sync) |-> (ovh_valid && word_idx == IDX_W'(CODE_LEN)));

  a_r7_drop_in_code_word: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_sync) |->
      (ovh_valid && word_idx != '0 && word_idx <= IDX_W'(CODE_LEN)));

  a_r8_enables_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stuff_pos && stuff_neg));

  a_r8_enables_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sync && !(ovh_valid && word_idx == IDX_W'(CODE_LEN))) |->
      ($stable(stuff_pos) && $stable(stuff_neg)));

  a_r9_enables_low_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |-> (!stuff_pos && !stuff_neg));

endmodule

bind stuff_frame_sync stuff_frame_sync_chk #(
  .FRAME_WORDS(FRAME_WORDS), .CODE_LEN(CODE_LEN), .PREFIX_LEN(PREFIX_LEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_en(word_en), .ovh_in(ovh_in),
  .ovh_valid(ovh_valid), .ovh_bit(ovh_bit), .word_idx(word_idx),
  .frame_end(frame_end), .prov_sync(prov_sync), .frame_sync(frame_sync),
  .stuff_pos(stuff_pos), .stuff_neg(stuff_neg)
);

// File: tb/stuff_frame_sync_bench.sv
module stuff_frame_sync_bench;

  localparam int CLK_PERIOD  = 10;
  localparam int FRAME_WORDS = 32;
  localparam int CODE_LEN    = 23;
  localparam int PREFIX_LEN  = 11;
  localparam int IDX_W       = 5;
  localparam logic [22:0] C_NONE = 23'h2B4D1E;
  localparam logic [22:0] C_POS  = 23'h65A0F3;
  localparam logic [22:0] C_NEG  = 23'h1C7E2D;
  localparam logic [22:0] CODES_TB [3] = '{C_NONE, C_POS, C_NEG};

  logic clk, rst_n, word_en, ovh_in;
  logic ovh_valid, ovh_bit, frame_end, prov_sync, frame_sync, stuff_pos, stuff_neg;
  logic [IDX_W-1:0] word_idx;

  int n_checks = 0;
  int n_err    = 0;
  bit cmp_on   = 0;
  bit done     = 0;

  stuff_frame_sync #(
    .FRAME_WORDS(FRAME_WORDS), .CODE_LEN(CODE_LEN), .PREFIX_LEN(PREFIX_LEN),
    .CODE_NONE(C_NONE), .CODE_POS(C_POS), .CODE_NEG(C_NEG)
  ) u_stuff_frame_sync (
    .clk(clk), .rst_n(rst_n), .word_en(word_en), .ovh_in(ovh_in),
    .ovh_valid(ovh_valid), .ovh_bit(ovh_bit), .word_idx(word_idx),
    .frame_end(frame_end), .prov_sync(prov_sync), .frame_sync(frame_sync),
    .stuff_pos(stuff_pos), .stuff_neg(stuff_neg)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  endtask

  function automatic bit code_bit(int k, int w);
    return CODES_TB[k][CODE_LEN-w];
  endfunction

  // Behavioural reference model, advanced on each rising edge.
  bit m_valid, m_bit, m_end, m_prov, m_sync, m_pos, m_neg;
  int m_idx, m_state;
  bit m_live[3];
  bit win[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_bit = 0; m_end = 0; m_prov = 0; m_sync = 0; m_pos = 0; m_neg = 0;
      m_idx = FRAME_WORDS - 1; m_state = 0;
      win.delete();
      for (int i = 0; i < PREFIX_LEN; i++) win.push_back(1'b0);
      for (int k = 0; k < 3; k++) m_live[k] = 0;
    end else begin
      m_valid = word_en; m_prov = 0; m_end = 0;
      if (word_en) begin
        bit b;
        int cur;
        b = ovh_in;
        m_bit = b;
        win.push_back(b);
        void'(win.pop_front());
        cur = (m_idx == FRAME_WORDS - 1) ? 0 : m_idx + 1;
        if (m_state == 0) begin
          int found;
          found = -1;
          for (int k = 0; k < 3; k++) begin
            bit ok;
            ok = 1;
            for (int i = 0; i < PREFIX_LEN; i++)
              if (win[i] != code_bit(k, i + 1)) ok = 0;
            if (ok && found < 0) found = k;
          end
          if (found >= 0) begin
            m_state = 1; m_prov = 1; m_idx = PREFIX_LEN;
            for (int k = 0; k < 3; k++) m_live[k] = (k == found);
          end else begin
            m_idx = cur;
          end
        end else begin
          m_idx = cur;
          if (cur >= 1 && cur <= CODE_LEN) begin
            bit any;
            any = 0;
            for (int k = 0; k < 3; k++) begin
              if (cur == 1) m_live[k] = 1;
              if (m_live[k] && code_bit(k, cur) != b) m_live[k] = 0;
              any |= m_live[k];
            end
            if (!any) m_state = 0;
            else if (cur == CODE_LEN) begin
              m_state = 2; m_pos = m_live[1]; m_neg = m_live[2];
            end
          end
        end
        m_end = (m_idx == FRAME_WORDS - 1);
      end
      m_sync = (m_state == 2);
      if (!m_sync) begin m_pos = 0; m_neg = 0; end
    end
  end

  // Per-cycle comparison and event monitor.
  int fall_idx = -1, prov_cnt = 0, prov_idx = -1, end_cnt = 0;
  bit prev_sync = 0;

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("R1 ovh_valid", ovh_valid, m_valid);
      check("R1 ovh_bit", ovh_bit, m_bit);
      check("R3 word_idx", word_idx, m_idx);
      check("R3 frame_end", frame_end, m_end);
      check("R2 prov_sync", prov_sync, m_prov);
      check("R4 frame_sync", frame_sync, m_sync);
      check("R8 stuff_pos", stuff_pos, m_pos);
      check("R8 stuff_neg", stuff_neg, m_neg);
      if (prev_sync && !frame_sync) fall_idx = word_idx;
      if (prov_sync) begin prov_cnt++; prov_idx = word_idx; end
      if (frame_end) end_cnt++;
      prev_sync = frame_sync;
    end
  end

  task automatic put(bit b);
    @(negedge clk);
    word_en = 1'b1;
    ovh_in  = b;
  endtask

  task automatic gap();
    @(negedge clk);
    word_en = 1'b0;
    ovh_in  = 1'($urandom);
  endtask

  task automatic send_frame(int k, int bad_word);
    for (int w = 0; w < FRAME_WORDS; w++) begin
      bit b;
      b = (w >= 1 && w <= CODE_LEN) ? code_bit(k, w) : 1'b0;
      if (w == bad_word) b = ~b;
      put(b);
      if (w % 7 == 3) gap();
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int ec;
    rst_n = 1'b0; word_en = 1'b0; ovh_in = 1'b0;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 ovh_valid", ovh_valid, 0);
    check("R10 word_idx", word_idx, FRAME_WORDS - 1);
    check("R10 prov_sync", prov_sync, 0);
    check("R10 frame_sync", frame_sync, 0);
    check("R10 stuff", {stuff_pos, stuff_neg}, 0);
    check("R10 frame_end", frame_end, 0);
    rst_n = 1'b1;
    cmp_on = 1;
    repeat (3) gap();

    // R2/R4: first clean frame locks within itself
    send_frame(0, -1); gap();
    check("R2 prov count", prov_cnt, 1);
    check("R2 prov word", prov_idx, PREFIX_LEN);
    check("R4 locked", frame_sync, 1);
    check("R8 none", {stuff_pos, stuff_neg}, 0);

    ec = end_cnt;
    send_frame(1, -1); gap();
    check("R8 pos", {stuff_pos, stuff_neg}, 2);
    check("R3 one end per frame", end_cnt - ec, 1);

    send_frame(2, -1); gap();
    check("R8 neg", {stuff_pos, stuff_neg}, 1);
    check("R6 no strobe in lock", prov_cnt, 1);

    send_frame(0, -1); gap();
    check("R8 back to none", {stuff_pos, stuff_neg}, 0);

    // R7: corrupt word 5 while locked
    send_frame(1, 5); gap();
    check("R7 drop word", fall_idx, 5);
    check("R9 unsynced", frame_sync, 0);
    check("R9 enables low", {stuff_pos, stuff_neg}, 0);

    // R5: prefix hits, confirmation fails at word 15
    ec = prov_cnt;
    send_frame(2, 15); gap();
    check("R5 strobe seen", (prov_cnt > ec) ? 1 : 0, 1);
    check("R5 not locked", frame_sync, 0);
    send_frame(1, -1);
    send_frame(1, -1); gap();
    check("R5 relock", frame_sync, 1);
    check("R5 relock pos", stuff_pos, 1);

    // Random traffic with gaps, then recovery
    for (int i = 0; i < 800; i++) begin
      put(1'($urandom));
      if ($urandom % 5 == 0) gap();
    end
    send_frame(2, -1);
    send_frame(2, -1); gap();
    check("R4 lock after noise", frame_sync, 1);
    check("R8 neg after noise", stuff_neg, 1);
    repeat (3) gap();
    finish_run();
  end

endmodule